// File: doc/BRIEF.md
# Coherence Directory Controller

This block is the bookkeeping point of a message-based coherence scheme for a group of private caches. For every cached line it holds a small entry: a state (Invalid, Shared or Modified) and a presence vector with one bit per cache. Caches send it three kinds of request, each tagged with the sender's cache index: a read-miss request, a write-miss request and an eviction notice. For each request the directory updates the entry and decides where the data comes from. The data comes either from the lower memory level or from a cache that already holds the line. The directory also sends snoop messages that make other caches give up or share their copy.

The entries live in a small set-associative structure rather than one entry per memory line. If a new line needs an entry and its set is full, an existing entry is displaced in round-robin order. Every cache still recorded in the displaced entry is told to invalidate that line. A request is accepted on every clock. All resulting messages appear together, registered, on the clock after the request. The data path and the network are outside this block.

Top module: `coh_dir_top`

## Requirements
- R1: After a synchronous active-low reset, no output message is valid and every entry is empty, so the first read or write request to any line is a miss that displaces nothing.
- R2: A read request (req_op = 0) that misses allocates an entry, raises mem_rd_valid and acknowledges with grant 1 (exclusive). The entry records the requester as sole, owning holder (Modified).
- R3: A read request that hits while at least one other cache is recorded sends a read snoop (snp_write = 0) to exactly one cache: the lowest-numbered other holder. That index appears in snp_src and as the only bit of snp_mask. The acknowledge carries grant 0 (shared), the requester is added to the holders and the entry becomes Shared. No memory read is issued.
- R4: A read request that hits while no other cache is recorded reads memory, acknowledges with grant 1 and leaves the requester as sole owner (Modified).
- R5: A write request (req_op = 1) that misses allocates an entry, raises mem_rd_valid and acknowledges with grant 2 (modified). The requester becomes sole owner.
- R6: A write request that hits while other caches are recorded sends a write snoop (snp_write = 1) whose snp_mask is every other holder. snp_src is the lowest-numbered of them, and no memory read is issued. Afterwards the requester is sole owner (Modified) and the acknowledge carries grant 2.
- R7: A write request that hits with no other holder reads memory and acknowledges with grant 2.
- R8: An eviction notice (req_op = 2) produces no output message. On a hit it clears the sender's bit, and when no bit remains the entry is freed: a later request to that line misses and displaces nothing. An eviction notice for an untracked line changes nothing.
- R9: The set index is the low log2(SETS) bits of req_addr. Allocation uses the lowest-numbered empty way of the set. When the set is full, a per-set round-robin pointer picks the way, starting at way 0 and advancing by one after each displacement. The clock carrying mem_rd_valid then also raises vic_valid, with vic_addr as the displaced line and vic_mask as its full holder vector.
- R10: Every message is valid for exactly the clock following its request. A clock with req_valid low, or with req_op = 3, produces no message and changes no entry.
- R11: Every read or write request is acknowledged (ack_cache, rsp_addr echo the requester and line), and exactly one of mem_rd_valid and snp_valid accompanies each acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this clock |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 eviction notice, 3 no operation |
| req_cache | input | log2(N_CACHES) | Index of the requesting cache |
| req_addr | input | ADDR_W | Line address; low bits select the set |
| ack_valid | output | 1 | Acknowledge to the requester |
| ack_cache | output | log2(N_CACHES) | Cache being acknowledged |
| ack_grant | output | 2 | 0 shared, 1 exclusive, 2 modified |
| rsp_addr | output | ADDR_W | Line address of the acknowledged request |
| mem_rd_valid | output | 1 | Fetch the line from the lower level |
| snp_valid | output | 1 | Snoop message to caches |
| snp_write | output | 1 | 1 invalidating snoop, 0 sharing snoop |
| snp_mask | output | N_CACHES | Caches receiving the snoop |
| snp_src | output | log2(N_CACHES) | Cache that supplies the data |
| vic_valid | output | 1 | Displaced entry: invalidate its holders |
| vic_addr | output | ADDR_W | Line address of the displaced entry |
| vic_mask | output | N_CACHES | Caches that must drop the displaced line |

## Verification
The hardest case to reach from the ports is displacement of an entry that still has several holders after a mix of sharing and partial evictions. In that case the round-robin pointer has moved away from way 0 and the victim's holder vector is neither full nor a single bit. The bench reaches it by first filling one set with a directed sequence. It then runs a long pseudo-random stream that draws from three tags per set across a two-way configuration, so sets overflow constantly while reads, writes and evictions reshape the holder vectors. An arithmetic model in the bench tracks every entry and the pointers, and the bench counts that each scenario was actually reached.

// File: rtl/coh_dir_pkg.sv
// Shared encodings for the coherence directory.
package coh_dir_pkg;

    // Request opcodes seen on req_op.
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NONE  = 2'd3
    } dir_op_e;

    // Directory entry state.
    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_MOD = 2'd2
    } dir_state_e;

    // Permission given with an acknowledge.
    typedef enum logic [1:0] {
        GR_SHARED = 2'd0,
        GR_EXCL   = 2'd1,
        GR_MOD    = 2'd2
    } dir_grant_e;

endpackage

// File: rtl/coh_dir_store.sv
// Entry storage: SETS x WAYS entries of state, tag and holder vector.
// Assumes one read set and at most one written entry per clock; the write
// becomes visible to the lookup of the following clock.
module coh_dir_store #(
    parameter int SETS     = 4,
    parameter int WAYS     = 2,
    parameter int TAG_W    = 10,
    parameter int N_CACHES = 4,
    parameter int SET_W    = 2,
    parameter int WAY_W    = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [SET_W-1:0]                  rd_set,
    output logic [WAYS-1:0][1:0]              rd_state,
    output logic [WAYS-1:0][TAG_W-1:0]        rd_tag,
    output logic [WAYS-1:0][N_CACHES-1:0]     rd_shr,
    input  logic                              wr_en,
    input  logic [SET_W-1:0]                  wr_set,
    input  logic [WAY_W-1:0]                  wr_way,
    input  logic [1:0]                        wr_state,
    input  logic [TAG_W-1:0]                  wr_tag,
    input  logic [N_CACHES-1:0]               wr_shr
);
    import coh_dir_pkg::*;

    logic [1:0]          st_q  [SETS][WAYS];
    logic [TAG_W-1:0]    tag_q [SETS][WAYS];
    logic [N_CACHES-1:0] shr_q [SETS][WAYS];

    // Update the single addressed entry, clear everything on reset.
    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (!rst_n) begin
                    st_q[s][w]  <= ST_INV;
                    tag_q[s][w] <= '0;
                    shr_q[s][w] <= '0;
                end else if (wr_en && wr_set == SET_W'(s) && wr_way == WAY_W'(w)) begin
                    st_q[s][w]  <= wr_state;
                    tag_q[s][w] <= wr_tag;
                    shr_q[s][w] <= wr_shr;
                end
            end
        end
    end

    // Present every way of the looked-up set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_state[w] = st_q[rd_set][w];
            rd_tag[w]   = tag_q[rd_set][w];
            rd_shr[w]   = shr_q[rd_set][w];
        end
    end

endmodule

// File: rtl/coh_dir_way_sel.sv
// Tag compare and allocation choice for one set.
// Assumes at most one valid way holds a given tag.
module coh_dir_way_sel #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 10,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0][1:0]       rd_state,
    input  logic [WAYS-1:0][TAG_W-1:0] rd_tag,
    input  logic [TAG_W-1:0]           lk_tag,
    input  logic [WAY_W-1:0]           rr_way,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic [WAY_W-1:0]           alloc_way,
    output logic                       alloc_displaces
);
    import coh_dir_pkg::*;

    logic [WAYS-1:0] hit_vec;
    logic [WAYS-1:0] free_vec;

    // Per-way match and emptiness flags.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w]  = (rd_state[w] != ST_INV) && (rd_tag[w] == lk_tag);
        assign free_vec[w] = (rd_state[w] == ST_INV);
    end

    // Encode the hitting way and the lowest free way.
    always_comb begin
        logic [WAY_W-1:0] first_free;
        hit_way    = '0;
        first_free = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])  hit_way    = WAY_W'(w);
            if (free_vec[w]) first_free = WAY_W'(w);
        end
        hit             = |hit_vec;
        alloc_displaces = ~|free_vec;
        alloc_way       = alloc_displaces ? rr_way : first_free;
    end

endmodule

// File: rtl/coh_dir_rr.sv
// Per-set round-robin displacement pointer, starting at way 0.
module coh_dir_rr #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int SET_W = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] rr_way,
    input  logic             adv,
    input  logic [SET_W-1:0] adv_set
);
    logic [WAY_W-1:0] ptr_q [SETS];

    // Step the pointer of a set each time one of its entries is displaced.
    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            if (!rst_n) begin
                ptr_q[s] <= '0;
            end else if (adv && adv_set == SET_W'(s)) begin
                ptr_q[s] <= (ptr_q[s] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[s] + 1'b1;
            end
        end
    end

    // Pointer of the set under lookup.
    assign rr_way = ptr_q[rd_set];

endmodule

// File: rtl/coh_dir_policy.sv
// Protocol decision: from the request and the matched entry, compute the
// entry update and every outgoing message. Purely combinational.
// Assumes entry fields are meaningful only when hit is high.
module coh_dir_policy #(
    parameter int N_CACHES = 4,
    parameter int ID_W     = 2
) (
    input  logic                go,
    input  logic [1:0]          op,
    input  logic [ID_W-1:0]     req_id,
    input  logic                hit,
    input  logic [1:0]          ent_state,
    input  logic [N_CACHES-1:0] ent_shr,
    output logic                upd,
    output logic                alloc,
    output logic [1:0]          new_state,
    output logic [N_CACHES-1:0] new_shr,
    output logic                ack_v,
    output logic [1:0]          grant,
    output logic                mem_rd,
    output logic                snp_v,
    output logic                snp_w,
    output logic [N_CACHES-1:0] snp_mask,
    output logic [ID_W-1:0]     snp_src
);
    import coh_dir_pkg::*;

    logic [N_CACHES-1:0] req_bit;
    logic [N_CACHES-1:0] others;
    logic                have_others;
    logic [ID_W-1:0]     supplier;

    assign req_bit     = N_CACHES'(1) << req_id;
    assign others      = ent_shr & ~req_bit;
    assign have_others = hit && (others != '0);

    // Lowest-numbered other holder supplies the data.
    always_comb begin
        supplier = '0;
        for (int i = N_CACHES - 1; i >= 0; i--) begin
            if (others[i]) supplier = ID_W'(i);
        end
    end

    // Decide update and messages for each opcode.
    always_comb begin
        upd       = 1'b0;
        alloc     = 1'b0;
        new_state = ent_state;
        new_shr   = ent_shr;
        ack_v     = 1'b0;
        grant     = GR_SHARED;
        mem_rd    = 1'b0;
        snp_v     = 1'b0;
        snp_w     = 1'b0;
        snp_mask  = '0;
        snp_src   = '0;
        if (go) begin
            case (op)
                OP_READ: begin
                    ack_v = 1'b1;
                    upd   = 1'b1;
                    if (have_others) begin
                        snp_v     = 1'b1;
                        snp_mask  = N_CACHES'(1) << supplier;
                        snp_src   = supplier;
                        grant     = GR_SHARED;
                        new_shr   = ent_shr | req_bit;
                        new_state = ST_SHR;
                    end else begin
                        mem_rd    = 1'b1;
                        alloc     = !hit;
                        grant     = GR_EXCL;
                        new_shr   = req_bit;
                        new_state = ST_MOD;
                    end
                end
                OP_WRITE: begin
                    ack_v     = 1'b1;
                    upd       = 1'b1;
                    alloc     = !hit;
                    grant     = GR_MOD;
                    new_shr   = req_bit;
                    new_state = ST_MOD;
                    if (have_others) begin
                        snp_v    = 1'b1;
                        snp_w    = 1'b1;
                        snp_mask = others;
                        snp_src  = supplier;
                    end else begin
                        mem_rd = 1'b1;
                    end
                end
                OP_EVICT: begin
                    if (hit) begin
                        upd       = 1'b1;
                        new_shr   = others;
                        new_state = (others == '0) ? ST_INV : ent_state;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/coh_dir_top.sv
// Coherence directory: set-associative entry store, protocol decision and
// registered message outputs. One request per clock; all messages for a
// request appear together on the following clock for exactly one clock.
module coh_dir_top #(
    parameter int N_CACHES = 4,
    parameter int ADDR_W   = 12,
    parameter int SETS     = 4,
    parameter int WAYS     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [1:0]                  req_op,
    input  logic [$clog2(N_CACHES)-1:0] req_cache,
    input  logic [ADDR_W-1:0]           req_addr,
    output logic                        ack_valid,
    output logic [$clog2(N_CACHES)-1:0] ack_cache,
    output logic [1:0]                  ack_grant,
    output logic [ADDR_W-1:0]           rsp_addr,
    output logic                        mem_rd_valid,
    output logic                        snp_valid,
    output logic                        snp_write,
    output logic [N_CACHES-1:0]         snp_mask,
    output logic [$clog2(N_CACHES)-1:0] snp_src,
    output logic                        vic_valid,
    output logic [ADDR_W-1:0]           vic_addr,
    output logic [N_CACHES-1:0]         vic_mask
);
    import coh_dir_pkg::*;

    localparam int ID_W  = $clog2(N_CACHES);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - SET_W;

    logic [SET_W-1:0]              set_idx;
    logic [TAG_W-1:0]              lk_tag;
    logic [WAYS-1:0][1:0]          rd_state;
    logic [WAYS-1:0][TAG_W-1:0]    rd_tag;
    logic [WAYS-1:0][N_CACHES-1:0] rd_shr;
    logic [WAY_W-1:0]              rr_way, hit_way, alloc_way, sel_way;
    logic                          hit, alloc_displaces;
    logic                          go;
    logic                          upd, alloc;
    logic [1:0]                    new_state, grant;
    logic [N_CACHES-1:0]           new_shr, p_snp_mask;
    logic                          p_ack, p_mem, p_snp, p_snp_w;
    logic [ID_W-1:0]               p_snp_src;
    logic                          p_vic;

    assign set_idx = req_addr[SET_W-1:0];
    assign lk_tag  = req_addr[ADDR_W-1:SET_W];
    assign go      = req_valid && (req_op != OP_NONE);
    assign sel_way = hit ? hit_way : alloc_way;
    assign p_vic   = alloc && alloc_displaces;

    coh_dir_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .N_CACHES(N_CACHES),
        .SET_W(SET_W), .WAY_W(WAY_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .rd_set(set_idx),
        .rd_state(rd_state), .rd_tag(rd_tag), .rd_shr(rd_shr),
        .wr_en(upd), .wr_set(set_idx), .wr_way(sel_way),
        .wr_state(new_state), .wr_tag(lk_tag), .wr_shr(new_shr)
    );

    coh_dir_rr #(
        .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
    ) rr_i (
        .clk(clk), .rst_n(rst_n), .rd_set(set_idx), .rr_way(rr_way),
        .adv(p_vic), .adv_set(set_idx)
    );

    coh_dir_way_sel #(
        .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) sel_i (
        .rd_state(rd_state), .rd_tag(rd_tag), .lk_tag(lk_tag), .rr_way(rr_way),
        .hit(hit), .hit_way(hit_way), .alloc_way(alloc_way),
        .alloc_displaces(alloc_displaces)
    );

    coh_dir_policy #(
        .N_CACHES(N_CACHES), .ID_W(ID_W)
    ) pol_i (
        .go(go), .op(req_op), .req_id(req_cache), .hit(hit),
        .ent_state(rd_state[hit_way]), .ent_shr(rd_shr[hit_way]),
        .upd(upd), .alloc(alloc), .new_state(new_state), .new_shr(new_shr),
        .ack_v(p_ack), .grant(grant), .mem_rd(p_mem), .snp_v(p_snp),
        .snp_w(p_snp_w), .snp_mask(p_snp_mask), .snp_src(p_snp_src)
    );

    // Register all messages of the current request for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid    <= 1'b0;
            ack_cache    <= '0;
            ack_grant    <= '0;
            rsp_addr     <= '0;
            mem_rd_valid <= 1'b0;
            snp_valid    <= 1'b0;
            snp_write    <= 1'b0;
            snp_mask     <= '0;
            snp_src      <= '0;
            vic_valid    <= 1'b0;
            vic_addr     <= '0;
            vic_mask     <= '0;
        end else begin
            ack_valid    <= p_ack;
            ack_cache    <= p_ack ? req_cache : '0;
            ack_grant    <= p_ack ? grant : '0;
            rsp_addr     <= p_ack ? req_addr : '0;
            mem_rd_valid <= p_mem;
            snp_valid    <= p_snp;
            snp_write    <= p_snp_w;
            snp_mask     <= p_snp_mask;
            snp_src      <= p_snp_src;
            vic_valid    <= p_vic;
            vic_addr     <= p_vic ? {rd_tag[alloc_way], set_idx} : '0;
            vic_mask     <= p_vic ? rd_shr[alloc_way] : '0;
        end
    end

endmodule

// File: rtl/coh_dir_checker.sv
// Protocol properties of the directory outputs, bound to coh_dir_top.
module coh_dir_checker #(
    parameter int N_CACHES = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic [1:0]                  req_op,
    input logic                        ack_valid,
    input logic [$clog2(N_CACHES)-1:0] ack_cache,
    input logic                        mem_rd_valid,
    input logic                        snp_valid,
    input logic                        snp_write,
    input logic [N_CACHES-1:0]         snp_mask,
    input logic [$clog2(N_CACHES)-1:0] snp_src,
    input logic                        vic_valid,
    input logic [N_CACHES-1:0]         vic_mask
);
    AST_ONE_DATA_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) ack_valid |-> (mem_rd_valid ^ snp_valid)); // R11
    AST_SOURCE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd_valid || snp_valid) |-> ack_valid); // R11
    AST_READ_SNOOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (snp_valid && !snp_write) |-> ($countones(snp_mask) == 1)); // R3
    AST_SUPPLIER_TARGETED: assert property (@(posedge clk) disable iff (!rst_n) snp_valid |-> snp_mask[snp_src]); // R6
    AST_SNOOP_SKIPS_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n) snp_valid |-> !snp_mask[ack_cache]); // R6
    AST_EVICT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_op == 2'd2) |=> !(ack_valid || mem_rd_valid || snp_valid || vic_valid)); // R8
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (!req_valid || req_op == 2'd3) |=> !(ack_valid || mem_rd_valid || snp_valid || vic_valid)); // R10
    AST_VICTIM_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n) vic_valid |-> (mem_rd_valid && vic_mask != '0)); // R9
endmodule

bind coh_dir_top coh_dir_checker #(.N_CACHES(N_CACHES)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .ack_valid(ack_valid), .ack_cache(ack_cache), .mem_rd_valid(mem_rd_valid),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_mask(snp_mask),
    .snp_src(snp_src), .vic_valid(vic_valid), .vic_mask(vic_mask)
);

// File: tb/coh_dir_top_tb_top.sv
module coh_dir_top_tb_top;
    localparam int N     = 4;
    localparam int AW    = 12;
    localparam int SETS  = 4;
    localparam int WAYS  = 2;
    localparam int SW    = 2;
    localparam int IW    = 2;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [IW-1:0] req_cache = '0;
    logic [AW-1:0] req_addr = '0;
    logic ack_valid, mem_rd_valid, snp_valid, snp_write, vic_valid;
    logic [IW-1:0] ack_cache, snp_src;
    logic [1:0] ack_grant;
    logic [AW-1:0] rsp_addr, vic_addr;
    logic [N-1:0] snp_mask, vic_mask;

    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;
    int cov [12];

    // model of the directory, from the requirements
    int m_st  [SETS][WAYS];
    int m_tag [SETS][WAYS];
    int m_shr [SETS][WAYS];
    int m_rr  [SETS];

    // expected outputs
    int e_ack, e_cache, e_grant, e_addr, e_mem, e_snp, e_snpw, e_mask, e_src;
    int e_vic, e_vaddr, e_vmask;
    string e_req;

    coh_dir_top #(.N_CACHES(N), .ADDR_W(AW), .SETS(SETS), .WAYS(WAYS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_cache(req_cache), .req_addr(req_addr), .ack_valid(ack_valid),
        .ack_cache(ack_cache), .ack_grant(ack_grant), .rsp_addr(rsp_addr),
        .mem_rd_valid(mem_rd_valid), .snp_valid(snp_valid), .snp_write(snp_write),
        .snp_mask(snp_mask), .snp_src(snp_src), .vic_valid(vic_valid),
        .vic_addr(vic_addr), .vic_mask(vic_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int lowest(input int v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic quiet_expect();
        e_ack = 0; e_cache = 0; e_grant = 0; e_addr = 0; e_mem = 0; e_snp = 0;
        e_snpw = 0; e_mask = 0; e_src = 0; e_vic = 0; e_vaddr = 0; e_vmask = 0;
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_st[s][w] = 0; m_tag[s][w] = 0; m_shr[s][w] = 0;
            end
        end
    endtask

    // Compute the expected outputs of one request and update the model.
    task automatic model_step(input int op, input int id, input int addr);
        int set, tag, hw, bitv, oth, fw;
        quiet_expect();
        set = addr % SETS;
        tag = addr >> SW;
        bitv = 1 << id;
        hw = -1;
        for (int w = 0; w < WAYS; w++)
            if (m_st[set][w] != 0 && m_tag[set][w] == tag) hw = w;
        oth = (hw >= 0) ? (m_shr[set][hw] & ~bitv) : 0;
        e_req = "R10";
        if (op == 0 || op == 1) begin
            e_ack = 1; e_cache = id; e_addr = addr;
            if (hw >= 0 && oth != 0) begin
                e_snp = 1; e_src = lowest(oth);
                if (op == 0) begin
                    e_snpw = 0; e_mask = 1 << e_src; e_grant = 0;
                    m_shr[set][hw] = m_shr[set][hw] | bitv; m_st[set][hw] = 1;
                    e_req = "R3"; cov[3]++;
                end else begin
                    e_snpw = 1; e_mask = oth; e_grant = 2;
                    m_shr[set][hw] = bitv; m_st[set][hw] = 2;
                    e_req = "R6"; cov[6]++;
                end
            end else begin
                e_mem = 1;
                e_grant = (op == 0) ? 1 : 2;
                if (hw < 0) begin
                    fw = -1;
                    for (int w = WAYS - 1; w >= 0; w--) if (m_st[set][w] == 0) fw = w;
                    if (fw < 0) begin
                        fw = m_rr[set];
                        e_vic = 1;
                        e_vaddr = (m_tag[set][fw] << SW) | set;
                        e_vmask = m_shr[set][fw];
                        m_rr[set] = (m_rr[set] + 1) % WAYS;
                        cov[9]++;
                    end
                    hw = fw;
                    m_tag[set][hw] = tag;
                    e_req = (op == 0) ? "R2" : "R5";
                    cov[(op == 0) ? 2 : 5]++;
                    if (e_vic != 0) e_req = "R9";
                end else begin
                    e_req = (op == 0) ? "R4" : "R7";
                    cov[(op == 0) ? 4 : 7]++;
                end
                m_shr[set][hw] = bitv; m_st[set][hw] = 2;
            end
        end else if (op == 2) begin
            e_req = "R8";
            if (hw >= 0) begin
                m_shr[set][hw] = oth;
                if (oth == 0) m_st[set][hw] = 0;
                cov[8]++;
            end
        end
    endtask

    task automatic compare(input string tag);
        bit ok;
        ok = (ack_valid == e_ack[0]) && (mem_rd_valid == e_mem[0]) &&
             (snp_valid == e_snp[0]) && (vic_valid == e_vic[0]);
        if (e_ack != 0)
            ok = ok && (ack_cache == IW'(e_cache)) && (ack_grant == 2'(e_grant)) &&
                 (rsp_addr == AW'(e_addr));
        if (e_snp != 0)
            ok = ok && (snp_write == e_snpw[0]) && (snp_mask == N'(e_mask)) &&
                 (snp_src == IW'(e_src));
        if (e_vic != 0)
            ok = ok && (vic_addr == AW'(e_vaddr)) && (vic_mask == N'(e_vmask));
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual ack=%0b c=%0d g=%0d a=%0h mem=%0b snp=%0b w=%0b m=%0h s=%0d vic=%0b va=%0h vm=%0h expected ack=%0d c=%0d g=%0d a=%0h mem=%0d snp=%0d w=%0d m=%0h s=%0d vic=%0d va=%0h vm=%0h",
                     tag, ack_valid, ack_cache, ack_grant, rsp_addr, mem_rd_valid, snp_valid,
                     snp_write, snp_mask, snp_src, vic_valid, vic_addr, vic_mask,
                     e_ack, e_cache, e_grant, e_addr, e_mem, e_snp, e_snpw, e_mask, e_src,
                     e_vic, e_vaddr, e_vmask);
        end
    endtask

    // One request: drive at the falling edge, check after the next rising edge.
    task automatic send(input int valid, input int op, input int id, input int addr);
        @(negedge clk);
        req_valid = valid[0];
        req_op = 2'(op);
        req_cache = IW'(id);
        req_addr = AW'(addr);
        if (valid != 0) model_step(op, id, addr);
        else begin quiet_expect(); e_req = "R10"; end
        @(posedge clk);
        #(CLK_PERIOD/4);
        req_valid = 1'b0;
        compare(e_req);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG_CYCLES) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG_CYCLES);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lf;
        for (int i = 0; i < 12; i++) cov[i] = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R1: outputs quiet while in reset
        quiet_expect();
        compare("R1");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first accesses after reset miss without displacement
        send(1, 0, 0, 'h010);          // R2 read miss
        send(1, 0, 1, 'h010);          // R3 from owner 0
        send(1, 0, 2, 'h010);          // R3 supplier 0
        send(1, 1, 3, 'h010);          // R6 mask 0,1,2
        send(1, 1, 3, 'h010);          // R7 sole holder
        send(1, 0, 3, 'h010);          // R4
        send(1, 2, 3, 'h010);          // R8 entry freed
        send(1, 2, 1, 'h010);          // R8 untracked, ignored
        send(1, 0, 1, 'h010);          // R8 line misses again, no victim
        send(1, 1, 2, 'h020);          // R5 write miss, way 1
        send(1, 0, 0, 'h020);          // R3 from writer 2
        send(1, 0, 3, 'h030);          // R9 displace way 0 (line 0x10)
        send(1, 1, 1, 'h040);          // R9 displace way 1 (line 0x20, mask 2 and 0)
        send(1, 3, 2, 'h040);          // R10 no-op opcode
        send(1, 0, 2, 'h040);          // R3 no-op changed nothing
        send(0, 0, 0, 'h040);          // R10 idle
        send(1, 2, 0, 'h011);          // R8 evict miss in another set
        // near-exhaustive pseudo-random sweep over a tiny line space
        lf = 16'hACE1;
        for (int k = 0; k < 6000; k++) begin
            int op, id, set, tsel;
            lf = ((lf >> 1) | ((((lf >> 0) ^ (lf >> 2) ^ (lf >> 3) ^ (lf >> 5)) & 1) << 15)) & 16'hFFFF;
            case (lf % 8)
                0, 1, 2: op = 0;
                3, 4:    op = 1;
                5, 6:    op = 2;
                default: op = 3;
            endcase
            id = (lf >> 3) % N;
            set = (lf >> 5) % SETS;
            tsel = ((lf >> 7) % 3) + 1;
            send((lf >> 12) % 16 != 0 ? 1 : 0, op, id, (tsel << SW) | set);
        end
        // scenario coverage: each listed case must have been reached
        for (int r = 2; r < 10; r++) begin
            n_tests++;
            if (cov[r] == 0) begin
                n_fail++;
                $display("FAIL R%0d coverage: actual 0 expected >0", r);
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule